// File: doc/BRIEF.md
# Radio Interrupt Status and Transmit Observe Registers

This block keeps the interrupt flags and the link statistics of a packet radio's control interface. The link engine reports events to it as one-cycle pulses: a payload landed in the receive queue, a packet left the transmitter, an acknowledgement came back, the retry budget ran out, a retry was attempted, a packet was given up as lost, and a new packet started. The block also follows the pipe number at the head of the receive queue and the full and empty flags of the two queues. Software clears flags by writing ones to them through the register write port.

The status byte sits at address 7. The observe byte sits at address 8, with the lost-packet count in the high nibble and the retry count of the current packet in the low nibble. Address 9 returns the live power-detect input in bit 0. A snapshot of the status byte is taken at the start of each serial command, so it can be shifted out while the command byte comes in. While the retry-limit flag is set, the block holds `tx_block` high and the transmitter stays idle.

Top module: `rstat_regs`

## Requirements
- R1: After reset the status byte reads 0x0E, the observe byte reads 0x00, `stat_byte` is 0x0E and `tx_block` is 0.
- R2: Status bit 6 (receive ready) is set in the cycle after `ev_rx_pkt`. It stays set until a write to address 7 with bit 6 high. Writing 0 to it has no effect.
- R3: Status bit 5 (sent) is set by `ev_ack_rx` when `auto_ack_en` is 1, and by `ev_tx_done` when `auto_ack_en` is 0. The other pulse has no effect. The bit is cleared by writing 1 to bit 5.
- R4: Status bit 4 (retry limit) is set by `ev_max_retry` and cleared by writing 1 to bit 4. `tx_block` is high exactly while it is set.
- R5: If a set event and a write-1 clear of the same flag fall in the same cycle, the flag ends up set.
- R6: Status bits 3:1 show, one cycle late, 111 when `rx_empty` is 1 and `head_pipe` otherwise. Writes do not change them.
- R7: Status bit 0 shows `tx_full` one cycle late. Bit 7 always reads 0, even after 1 is written to it.
- R8: Observe bits 7:4 count `ev_lost` pulses and saturate at 15. Only a write to address `CH_ADDR` (default 5) resets them. A loss that arrives together with that write leaves the count at 1. Writes to address 8 change nothing.
- R9: Observe bits 3:0 count `ev_retry` pulses and saturate at 15. `ev_new_pkt` resets them to 0, and it wins over a retry in the same cycle.
- R10: Reading address 9 returns `{7'b0, rpd}` from the live input. Writes to address 9 have no effect.
- R11: On a cycle with `cmd_start` high, `stat_byte` takes the status value held before that edge. It does not change on any other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_rx_pkt | input | 1 | Payload written into the receive queue |
| ev_tx_done | input | 1 | Packet left the transmitter |
| ev_ack_rx | input | 1 | Acknowledgement received |
| ev_max_retry | input | 1 | Retry budget exhausted |
| ev_retry | input | 1 | Retransmission attempted |
| ev_lost | input | 1 | Packet declared lost |
| ev_new_pkt | input | 1 | Transmission of a new packet begins |
| auto_ack_en | input | 1 | Acknowledged mode selects the source of the sent flag |
| head_pipe | input | 3 | Pipe number of the receive queue head |
| rx_empty | input | 1 | Receive queue empty |
| tx_full | input | 1 | Transmit queue full |
| rpd | input | 1 | Received power detect |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | AW | Read address |
| rd_data | output | 8 | Read data, combinational from `rd_addr` |
| cmd_start | input | 1 | First cycle of a serial command |
| stat_byte | output | 8 | Status snapshot for serial shift-out |
| tx_block | output | 1 | Transmission inhibited |

## Verification
A stuck or wrongly cleared flag shows in the status read on the cycle after its event or write. If the retry-limit flag is wrong, `tx_block` is wrong in that same cycle. A counter that fails to saturate or clear shows up at the first pulse past 15 or at the first clearing trigger, and the lost and retry nibbles are compared independently on every step. A snapshot taken at the wrong edge shows immediately as a `stat_byte` that includes or misses the event that coincided with `cmd_start`.

// File: rtl/rstat_regs.sv
module rstat_regs #(
  parameter int AW        = 5,
  parameter int STAT_ADDR = 7,
  parameter int OBS_ADDR  = 8,
  parameter int RPD_ADDR  = 9,
  parameter int CH_ADDR   = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_rx_pkt,
  input  logic          ev_tx_done,
  input  logic          ev_ack_rx,
  input  logic          ev_max_retry,
  input  logic          ev_retry,
  input  logic          ev_lost,
  input  logic          ev_new_pkt,
  input  logic          auto_ack_en,
  input  logic [2:0]    head_pipe,
  input  logic          rx_empty,
  input  logic          tx_full,
  input  logic          rpd,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  input  logic          cmd_start,
  output logic [7:0]    stat_byte,
  output logic          tx_block
);
  localparam int CW = 4;
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  logic          rx_dr_q, ds_q, mr_q, full_q;
  logic [2:0]    pipe_q;
  logic [CW-1:0] lost_q, retry_q;
  logic [7:0]    cap_q;

  logic wr_stat, wr_ch, ds_set;
  logic [CW-1:0] lost_base;
  logic [7:0] status_w, observe_w;

  assign wr_stat  = wr_en && (wr_addr == AW'(STAT_ADDR));
  assign wr_ch    = wr_en && (wr_addr == AW'(CH_ADDR));
  assign ds_set   = auto_ack_en ? ev_ack_rx : ev_tx_done;
  assign lost_base = wr_ch ? '0 : lost_q;

  assign status_w  = {1'b0, rx_dr_q, ds_q, mr_q, pipe_q, full_q};
  assign observe_w = {lost_q, retry_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_dr_q <= 1'b0;
      ds_q    <= 1'b0;
      mr_q    <= 1'b0;
      pipe_q  <= 3'b111;
      full_q  <= 1'b0;
      lost_q  <= '0;
      retry_q <= '0;
      cap_q   <= 8'h0E;
    end else begin
      rx_dr_q <= ev_rx_pkt    | (rx_dr_q & ~(wr_stat & wr_data[6]));
      ds_q    <= ds_set       | (ds_q    & ~(wr_stat & wr_data[5]));
      mr_q    <= ev_max_retry | (mr_q    & ~(wr_stat & wr_data[4]));
      pipe_q  <= rx_empty ? 3'b111 : head_pipe;
      full_q  <= tx_full;
      lost_q  <= (ev_lost && lost_base != CMAX) ? lost_base + CW'(1) : lost_base;
      if (ev_new_pkt)
        retry_q <= '0;
      else if (ev_retry && retry_q != CMAX)
        retry_q <= retry_q + CW'(1);
      if (cmd_start)
        cap_q <= status_w;
    end
  end

  always_comb begin
    rd_data = 8'h00;
    if (rd_addr == AW'(STAT_ADDR))     rd_data = status_w;
    else if (rd_addr == AW'(OBS_ADDR)) rd_data = observe_w;
    else if (rd_addr == AW'(RPD_ADDR)) rd_data = {7'b0, rpd};
  end

  assign stat_byte = cap_q;
  assign tx_block  = mr_q;
endmodule

// File: rtl/rstat_regs_chk.sv
module rstat_regs_chk #(
  parameter int AW        = 5,
  parameter int STAT_ADDR = 7,
  parameter int CH_ADDR   = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ev_rx_pkt,
  input logic          ev_ack_rx,
  input logic          ev_max_retry,
  input logic          ev_new_pkt,
  input logic          auto_ack_en,
  input logic          rx_empty,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [7:0]    wr_data,
  input logic          cmd_start,
  input logic [7:0]    stat_byte,
  input logic          tx_block,
  input logic          rx_dr_q,
  input logic          ds_q,
  input logic          mr_q,
  input logic [2:0]    pipe_q,
  input logic [3:0]    lost_q,
  input logic [3:0]    retry_q
);
  logic wr_st, wr_ch;
  assign wr_st = wr_en && (wr_addr == AW'(STAT_ADDR));
  assign wr_ch = wr_en && (wr_addr == AW'(CH_ADDR));

  AST_RXDR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rx_pkt |=> rx_dr_q); // R2
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_max_retry && wr_st && wr_data[4]) |=> mr_q); // R5
  AST_DS_ACKONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_ack_en && !ev_ack_rx && !ds_q) |=> !ds_q); // R3
  AST_MAXRT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_block && !(wr_st && wr_data[4])) |=> tx_block); // R4
  AST_PIPE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    rx_empty |=> (pipe_q == 3'b111)); // R6
  AST_LOST_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (lost_q == 4'hF && !wr_ch) |=> (lost_q == 4'hF)); // R8
  AST_LOST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ch |=> (lost_q == $past(lost_q) || lost_q == $past(lost_q) + 4'd1)); // R8
  AST_RETRY_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    ev_new_pkt |=> (retry_q == 4'd0)); // R9
  AST_CAP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_start |=> $stable(stat_byte)); // R11
endmodule

bind rstat_regs rstat_regs_chk #(.AW(AW), .STAT_ADDR(STAT_ADDR), .CH_ADDR(CH_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_rx_pkt(ev_rx_pkt), .ev_ack_rx(ev_ack_rx),
  .ev_max_retry(ev_max_retry), .ev_new_pkt(ev_new_pkt), .auto_ack_en(auto_ack_en),
  .rx_empty(rx_empty), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .cmd_start(cmd_start), .stat_byte(stat_byte), .tx_block(tx_block),
  .rx_dr_q(rx_dr_q), .ds_q(ds_q), .mr_q(mr_q), .pipe_q(pipe_q),
  .lost_q(lost_q), .retry_q(retry_q)
);

// File: tb/rstat_regs_bench.sv
`timescale 1ns/1ps
module rstat_regs_bench;
  localparam int AW = 5;
  logic clk = 0, rst_n = 0;
  logic ev_rx_pkt = 0, ev_tx_done = 0, ev_ack_rx = 0, ev_max_retry = 0;
  logic ev_retry = 0, ev_lost = 0, ev_new_pkt = 0, auto_ack_en = 0;
  logic [2:0] head_pipe = 0;
  logic rx_empty = 1, tx_full = 0, rpd = 0, wr_en = 0, cmd_start = 0;
  logic [AW-1:0] wr_addr = 0, rd_addr = 0;
  logic [7:0] wr_data = 0, rd_data, stat_byte;
  logic tx_block;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rstat_regs u_rstat_regs (
    .clk(clk), .rst_n(rst_n), .ev_rx_pkt(ev_rx_pkt), .ev_tx_done(ev_tx_done),
    .ev_ack_rx(ev_ack_rx), .ev_max_retry(ev_max_retry), .ev_retry(ev_retry),
    .ev_lost(ev_lost), .ev_new_pkt(ev_new_pkt), .auto_ack_en(auto_ack_en),
    .head_pipe(head_pipe), .rx_empty(rx_empty), .tx_full(tx_full), .rpd(rpd),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .cmd_start(cmd_start), .stat_byte(stat_byte), .tx_block(tx_block));

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic rd(input int a, output logic [7:0] v);
    rd_addr = AW'(a); #0.5; v = rd_data;
  endtask

  task automatic wr(int a, logic [7:0] d);
    wr_en = 1; wr_addr = AW'(a); wr_data = d; tick(); wr_en = 0;
  endtask

  function automatic int sat(int n);
    return n > 15 ? 15 : n;
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, s0;
    @(negedge clk); @(negedge clk); rst_n = 1; @(negedge clk);
    // R1 reset values
    rd(7, v); chk("R1 status", v, 8'h0E);
    rd(8, v); chk("R1 observe", v, 8'h00);
    chk("R1 snapshot", stat_byte, 8'h0E);
    chk("R1 tx_block", {7'b0, tx_block}, 8'h00);

    // R6 R7 pipe field and full flag sweep
    for (int e = 0; e < 2; e++)
      for (int p = 0; p < 8; p++)
        for (int f = 0; f < 2; f++) begin
          rx_empty = e[0]; head_pipe = p[2:0]; tx_full = f[0];
          tick();
          rd(7, v);
          chk("R6 R7 pipe/full", v, {4'b0, (e != 0) ? 3'b111 : p[2:0], f[0]});
          wr(7, 8'hFF);
          rd(7, v);
          chk("R6 R7 write ignored, bit7 zero", v, {4'b0, (e != 0) ? 3'b111 : p[2:0], f[0]});
        end
    rx_empty = 1; tx_full = 0; tick();

    // R2 R4 write-1-to-clear sweep
    for (int s = 0; s < 8; s++)
      for (int m = 0; m < 8; m++) begin
        wr(7, 8'h70);
        ev_rx_pkt = s[2]; ev_tx_done = s[1]; ev_max_retry = s[0];
        tick();
        ev_rx_pkt = 0; ev_tx_done = 0; ev_max_retry = 0;
        rd(7, v); chk("R2 R4 set", v, {1'b0, s[2:0], 4'hE});
        wr(7, {1'b0, m[2:0], 4'h0});
        rd(7, v);
        chk("R2 R4 clear mask", v, {1'b0, s[2:0] & ~m[2:0], 4'hE});
        chk("R4 tx_block", {7'b0, tx_block}, {7'b0, s[0] & ~m[0]});
      end

    // R5 set beats clear
    for (int b = 4; b < 7; b++) begin
      wr(7, 8'h70);
      ev_rx_pkt = (b == 6); ev_tx_done = (b == 5); ev_max_retry = (b == 4);
      wr(7, 8'h70);
      ev_rx_pkt = 0; ev_tx_done = 0; ev_max_retry = 0;
      rd(7, v); chk("R5 set wins", v, 8'h0E | (8'h01 << b));
    end
    wr(7, 8'h70);

    // R3 sent source follows auto_ack_en
    auto_ack_en = 1;
    ev_tx_done = 1; tick(); ev_tx_done = 0;
    rd(7, v); chk("R3 auto: tx_done ignored", v, 8'h0E);
    ev_ack_rx = 1; tick(); ev_ack_rx = 0;
    rd(7, v); chk("R3 auto: ack sets", v, 8'h2E);
    wr(7, 8'h20); auto_ack_en = 0;
    ev_ack_rx = 1; tick(); ev_ack_rx = 0;
    rd(7, v); chk("R3 plain: ack ignored", v, 8'h0E);
    ev_tx_done = 1; tick(); ev_tx_done = 0;
    rd(7, v); chk("R3 plain: tx_done sets", v, 8'h2E);
    wr(7, 8'h20);

    // R8 lost counter
    wr(5, 8'h00);
    for (int n = 1; n <= 20; n++) begin
      ev_lost = 1; tick(); ev_lost = 0;
      rd(8, v); chk("R8 lost count", v, {4'(sat(n)), 4'h0});
    end
    wr(8, 8'h00); rd(8, v); chk("R8 write to observe ignored", v, 8'hF0);
    ev_lost = 1; wr(5, 8'h11); ev_lost = 0;
    rd(8, v); chk("R8 clear with loss", v, 8'h10);
    wr(5, 8'h00); rd(8, v); chk("R8 channel write clears", v, 8'h00);

    // R9 retry counter
    for (int n = 1; n <= 18; n++) begin
      ev_retry = 1; tick(); ev_retry = 0;
      rd(8, v); chk("R9 retry count", v, {4'h0, 4'(sat(n))});
    end
    ev_new_pkt = 1; tick(); ev_new_pkt = 0;
    rd(8, v); chk("R9 new packet clears", v, 8'h00);
    ev_retry = 1; tick();
    ev_new_pkt = 1; tick(); ev_retry = 0; ev_new_pkt = 0;
    rd(8, v); chk("R9 new packet wins", v, 8'h00);

    // R10 power detect
    rpd = 1; rd(9, v); chk("R10 rpd high", v, 8'h01);
    rpd = 0; wr(9, 8'hFF); rd(9, v); chk("R10 rpd low, write ignored", v, 8'h00);

    // R11 snapshot timing
    rd(7, s0);
    cmd_start = 1; ev_rx_pkt = 1; tick(); cmd_start = 0; ev_rx_pkt = 0;
    chk("R11 snapshot old value", stat_byte, s0);
    rd(7, v); chk("R11 live updated", v, s0 | 8'h40);
    tick(); chk("R11 snapshot holds", stat_byte, s0);
    cmd_start = 1; tick(); cmd_start = 0;
    chk("R11 snapshot refresh", stat_byte, s0 | 8'h40);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule